// File: doc/BRIEF.md
# Sampling Acquisition Start/Stop Controller

This block sequences the sample memory of a multi-channel digitizer. It takes external start and stop pulses, runs each of them through its own programmable delay, and decides in which clock cycles samples are written. While sampling is enabled it presents one write address per clock. It reports the end of an acquisition with a one-clock done pulse. After that it stays disarmed until a rearm pulse arrives.

Three mode inputs shape an acquisition. In start-stop operation, which is the default with all mode inputs low, the delayed start opens the window. The delayed stop closes it, or the window closes by itself once the selected number of samples has been written. The wrap bit turns the address into a ring over the selected size. Sampling then ends only on stop, and the address of the final write is kept as the wrap pointer. The free-running bit starts sampling as soon as the block is armed, and sampling then ends only on stop. The gate bit turns each delayed stop into a pause. Later delayed starts resume at the next address, and the acquisition ends at the count limit.

Top module: `acq_ctrl`

## Requirements
- R1: A start pulse sampled high at clock edge t makes samp_en_o high from edge t+start_dly_i+2 onward, provided the block is armed and sampling is not already running.
- R2: A stop pulse sampled high at edge t while sampling runs makes samp_en_o low from edge t+stop_dly_i+2 onward.
- R3: A start pulse that arrives while an earlier start is still being delayed is ignored, so the start time follows the first pulse.
- R4: With wrap_i, freerun_i and gate_i low, an acquisition writes exactly the selected number N of samples, at addresses 0, 1, ..., N-1 in consecutive cycles, and then ends by itself. The wrap pointer then holds N-1.
- R5: size_sel_i codes 0 to 7 select N = 131072, 16384, 4096, 2048, 1024, 512, 256 and 128 in that order. Code 1 (16K) is the usual setting.
- R6: With wrap_i high, the write address counts modulo N and the count limit does not end sampling. The delayed stop ends it, and wrap_ptr_o then holds the address of the last write.
- R7: With freerun_i high while armed, samp_en_o goes high one edge later without any start pulse. The address counts modulo N and sampling ends only on the delayed stop.
- R8: With gate_i high and freerun_i low, a delayed stop pauses sampling with no done pulse, and the write address holds. A later delayed start resumes at the next address, and the acquisition ends with done once N samples have been written in total.
- R9: done_o is high for exactly one clock at the end of every acquisition, and samp_en_o is low from that point on. Starts are ignored until rearm_i. Rearm returns the write address to 0 and arms the block again.
- R10: After reset, samp_en_o and done_o are low, and wr_addr_o and wrap_ptr_o are 0.
- R11: A stop pulse while the block is armed and idle has no effect: samp_en_o and done_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | External start pulse |
| stop_i | input | 1 | External stop pulse |
| rearm_i | input | 1 | Re-enables acquisition after done |
| freerun_i | input | 1 | Free-running mode |
| gate_i | input | 1 | Gated (pause/resume) mode |
| wrap_i | input | 1 | Ring-address mode |
| size_sel_i | input | 3 | Sample-count selector |
| start_dly_i | input | DLY_W | Programmed start delay |
| stop_dly_i | input | DLY_W | Programmed stop delay |
| samp_en_o | output | 1 | A sample is written this cycle |
| wr_addr_o | output | 17 | Write address for the current sample |
| done_o | output | 1 | One-clock end-of-acquisition pulse |
| wrap_ptr_o | output | 17 | Address of the last write of the finished acquisition |

## Verification
Several properties are checked on every cycle: done is a single-cycle pulse that never coincides with sampling, every done follows a cycle in which sampling ran, and sampling never falls without done unless gated operation is in force. They also check that the write address holds whenever nothing is written and stays inside the selected size. The exact latencies of delay+2 on both paths, the suppression of a second start, the sample counts of each size code, and the values of the wrap pointer can only be shown by the bench's scenarios. The bench sweeps the start delay and the size codes, and it follows the address of every written sample against a running count.

// File: rtl/acq_pkg.sv
package acq_pkg;

    localparam int ADDR_W = 17;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2,
        ST_HALT  = 2'd3
    } acq_state_e;

    typedef struct packed {
        logic limit_hit;
        logic stop_hit;
        logic finish;
        logic pause;
    } acq_evt_t;

    function automatic int size_log2(input logic [2:0] code);
        case (code)
            3'd0:    return 17;
            3'd1:    return 14;
            3'd2:    return 12;
            3'd3:    return 11;
            3'd4:    return 10;
            3'd5:    return 9;
            3'd6:    return 8;
            default: return 7;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] size_mask(input logic [2:0] code);
        logic [ADDR_W:0] one_hot;
        one_hot = (ADDR_W+1)'(1) << size_log2(code);
        return ADDR_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/acq_evdelay.sv
module acq_evdelay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             pulse_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             fire_o
);
    logic             busy_q;
    logic [DLY_W-1:0] cnt_q;

    // Accept edge, dly countdown edges, one edge to register fire: the
    // consumer acts on fire one edge later, dly+2 after acceptance.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            fire_o <= 1'b0;
        end else begin
            fire_o <= 1'b0;
            if (busy_q) begin
                if (cnt_q == '0) begin
                    fire_o <= 1'b1;
                    busy_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (en && pulse_i) begin
                busy_q <= 1'b1;
                cnt_q  <= dly_i;
            end
        end
    end
endmodule

// File: rtl/acq_waddr.sv
module acq_waddr
    import acq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              adv,
    input  logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    assign last_o = (addr_o == mask);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            addr_o <= '0;
        end else if (adv) begin
            addr_o <= last_o ? '0 : addr_o + 1'b1;
        end
    end
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
    import acq_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic                rearm_i,
    input  logic                freerun_i,
    input  logic                gate_i,
    input  logic                wrap_i,
    input  logic [2:0]          size_sel_i,
    input  logic [DLY_W-1:0]    start_dly_i,
    input  logic [DLY_W-1:0]    stop_dly_i,
    output logic                samp_en_o,
    output logic [ADDR_W-1:0]   wr_addr_o,
    output logic                done_o,
    output logic [ADDR_W-1:0]   wrap_ptr_o
);
    acq_state_e        state_q, state_d;
    acq_evt_t          evt;
    logic              start_fire, stop_fire;
    logic              start_en, stop_en;
    logic              addr_last, addr_clr, addr_adv;
    logic              ring_mode, gated;
    logic [ADDR_W-1:0] mask;

    assign mask      = size_mask(size_sel_i);
    assign ring_mode = wrap_i || freerun_i;
    assign gated     = gate_i && !freerun_i;
    assign start_en  = (state_q == ST_ARMED) || (state_q == ST_PAUSE);
    assign stop_en   = (state_q != ST_HALT);

    acq_evdelay #(.DLY_W(DLY_W)) u_start_dly (
        .clk(clk), .rst(rst), .en(start_en), .pulse_i(start_i),
        .dly_i(start_dly_i), .fire_o(start_fire)
    );

    acq_evdelay #(.DLY_W(DLY_W)) u_stop_dly (
        .clk(clk), .rst(rst), .en(stop_en), .pulse_i(stop_i),
        .dly_i(stop_dly_i), .fire_o(stop_fire)
    );

    always_comb begin
        evt.limit_hit = (state_q == ST_RUN) && addr_last && !ring_mode;
        evt.stop_hit  = (state_q == ST_RUN) && stop_fire;
        evt.finish    = evt.limit_hit || (evt.stop_hit && !gated);
        evt.pause     = evt.stop_hit && gated && !evt.limit_hit;
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_ARMED: if (freerun_i || start_fire) state_d = ST_RUN;
            ST_RUN: begin
                if (evt.finish)     state_d = ST_HALT;
                else if (evt.pause) state_d = ST_PAUSE;
            end
            ST_PAUSE: if (start_fire) state_d = ST_RUN;
            ST_HALT:  if (rearm_i)    state_d = ST_ARMED;
            default:  state_d = ST_ARMED;
        endcase
    end

    assign addr_clr = (state_q == ST_HALT) && rearm_i;
    assign addr_adv = (state_q == ST_RUN) && !evt.finish;

    acq_waddr u_waddr (
        .clk(clk), .rst(rst), .clr(addr_clr), .adv(addr_adv),
        .mask(mask), .addr_o(wr_addr_o), .last_o(addr_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_ARMED;
            done_o     <= 1'b0;
            wrap_ptr_o <= '0;
        end else begin
            state_q <= state_d;
            done_o  <= evt.finish;
            if (evt.finish) wrap_ptr_o <= wr_addr_o;
        end
    end

    assign samp_en_o = (state_q == ST_RUN);
endmodule

// File: rtl/acq_ctrl_chk.sv
module acq_ctrl_chk
    import acq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rearm_i,
    input logic              freerun_i,
    input logic              gate_i,
    input logic [2:0]        size_sel_i,
    input logic              samp_en_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] wr_addr_o
);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !samp_en_o);

    assert_done_after_run_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(samp_en_o));

    assert_end_reports_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(samp_en_o) && !(gate_i && !freerun_i)) |-> done_o);

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!samp_en_o && !rearm_i) |=> $stable(wr_addr_o));

    assert_addr_in_size_R5: assert property (@(posedge clk) disable iff (rst)
        samp_en_o |-> (wr_addr_o <= size_mask(size_sel_i)));
endmodule

bind acq_ctrl acq_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .rearm_i(rearm_i), .freerun_i(freerun_i),
    .gate_i(gate_i), .size_sel_i(size_sel_i), .samp_en_o(samp_en_o),
    .done_o(done_o), .wr_addr_o(wr_addr_o)
);

// File: tb/sim_acq_ctrl.sv
module sim_acq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, stop_i = 1'b0, rearm_i = 1'b0;
    logic        freerun_i = 1'b0, gate_i = 1'b0, wrap_i = 1'b0;
    logic [2:0]  size_sel_i = 3'd7;
    logic [7:0]  start_dly_i = '0, stop_dly_i = '0;
    logic        samp_en_o, done_o;
    logic [16:0] wr_addr_o, wrap_ptr_o;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int mod_n  = 128;
    int n;
    bit finished = 0;

    always #5 clk = ~clk;

    acq_ctrl #(.DLY_W(8)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
        .rearm_i(rearm_i), .freerun_i(freerun_i), .gate_i(gate_i),
        .wrap_i(wrap_i), .size_sel_i(size_sel_i), .start_dly_i(start_dly_i),
        .stop_dly_i(stop_dly_i), .samp_en_o(samp_en_o), .wr_addr_o(wr_addr_o),
        .done_o(done_o), .wrap_ptr_o(wrap_ptr_o)
    );

    function automatic int size_of(input int code);
        case (code)
            0: return 131072;
            1: return 16384;
            2: return 4096;
            3: return 2048;
            4: return 1024;
            5: return 512;
            6: return 256;
            default: return 128;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance to the next falling edge; every written sample has its address checked.
    task automatic step(input string req);
        @(negedge clk);
        if (samp_en_o) begin
            chk(wr_addr_o == 17'(wr_cnt % mod_n), req, wr_addr_o, wr_cnt % mod_n);
            wr_cnt++;
        end
    endtask

    // Start pulse, then count falling edges until sampling is seen.
    task automatic fire_start(input int d, input string req);
        start_dly_i = 8'(d);
        start_i = 1'b1;
        step(req);
        start_i = 1'b0;
        n = 0;
        while (!samp_en_o && n < 300) begin step(req); n++; end
        chk(n == d + 2, req, n, d + 2);
    endtask

    task automatic fire_stop(input int d, input string req);
        stop_dly_i = 8'(d);
        stop_i = 1'b1;
        step(req);
        stop_i = 1'b0;
        n = 0;
        while (samp_en_o && n < 300) begin step(req); n++; end
        chk(n == d + 2, req, n, d + 2);
    endtask

    task automatic run_out(input string req);
        int g = 0;
        while (samp_en_o && g < 140000) begin step(req); g++; end
    endtask

    task automatic expect_done(input string req);
        chk(done_o == 1'b1, req, done_o, 1);
        step(req);
        chk(done_o == 1'b0, req, done_o, 0);
    endtask

    task automatic do_rearm(input string req);
        rearm_i = 1'b1;
        step(req);
        rearm_i = 1'b0;
        wr_cnt = 0;
        chk(wr_addr_o == 17'd0, req, wr_addr_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step("R10");
        // R10 reset state
        chk(samp_en_o == 1'b0, "R10", samp_en_o, 0);
        chk(done_o == 1'b0, "R10", done_o, 0);
        chk(wr_addr_o == 17'd0, "R10", wr_addr_o, 0);
        chk(wrap_ptr_o == 17'd0, "R10", wrap_ptr_o, 0);

        // R11: stop while armed and idle has no effect
        stop_dly_i = 8'd0;
        stop_i = 1'b1; step("R11"); stop_i = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step("R11");
            chk(samp_en_o == 1'b0 && done_o == 1'b0, "R11", {samp_en_o, done_o}, 0);
        end

        // R1 and R4: sweep start delay on the smallest size
        mod_n = 128;
        for (int d = 0; d < 8; d++) begin
            fire_start(d, "R1");
            run_out("R4");
            chk(wr_cnt == 128, "R4", wr_cnt, 128);
            chk(wrap_ptr_o == 17'd127, "R4", wrap_ptr_o, 127);
            expect_done("R9");
            do_rearm("R9");
        end

        // R5: every size code but the largest runs to its own limit
        for (int c = 6; c >= 1; c--) begin
            size_sel_i = 3'(c);
            mod_n = size_of(c);
            fire_start(0, "R5");
            run_out("R5");
            chk(wr_cnt == size_of(c), "R5", wr_cnt, size_of(c));
            chk(wrap_ptr_o == 17'(size_of(c) - 1), "R5", wrap_ptr_o, size_of(c) - 1);
            expect_done("R5");
            do_rearm("R5");
        end

        // R3: second start while the first is delayed is ignored
        size_sel_i = 3'd7; mod_n = 128;
        start_dly_i = 8'd6;
        start_i = 1'b1; step("R3"); start_i = 1'b0;
        n = 0;
        step("R3"); n++;
        step("R3"); n++;
        start_i = 1'b1; step("R3"); n++; start_i = 1'b0;
        while (!samp_en_o && n < 300) begin step("R3"); n++; end
        chk(n == 8, "R3", n, 8);
        run_out("R3");
        chk(wr_cnt == 128, "R3", wr_cnt, 128);
        expect_done("R3");
        do_rearm("R3");

        // R2: stop latency in start-stop mode
        size_sel_i = 3'd5; mod_n = 512;
        for (int sd = 0; sd < 6; sd += 2) begin
            fire_start(0, "R2");
            repeat (20) step("R2");
            fire_stop(sd, "R2");
            chk(wrap_ptr_o == 17'(wr_cnt - 1), "R2", wrap_ptr_o, wr_cnt - 1);
            expect_done("R2");
            do_rearm("R2");
        end

        // R6: ring addressing beyond the limit, end only on stop
        size_sel_i = 3'd7; mod_n = 128; wrap_i = 1'b1;
        fire_start(1, "R6");
        repeat (300) step("R6");
        chk(samp_en_o == 1'b1, "R6", samp_en_o, 1);
        fire_stop(1, "R6");
        chk(wrap_ptr_o == 17'((wr_cnt - 1) % 128), "R6", wrap_ptr_o, (wr_cnt - 1) % 128);
        expect_done("R6");
        wrap_i = 1'b0;
        do_rearm("R6");

        // R7: free-running starts without a start pulse
        freerun_i = 1'b1;
        step("R7");
        chk(samp_en_o == 1'b1, "R7", samp_en_o, 1);
        repeat (400) step("R7");
        chk(samp_en_o == 1'b1, "R7", samp_en_o, 1);
        fire_stop(2, "R7");
        chk(wrap_ptr_o == 17'((wr_cnt - 1) % 128), "R7", wrap_ptr_o, (wr_cnt - 1) % 128);
        expect_done("R7");
        freerun_i = 1'b0;
        do_rearm("R7");

        // R8: gated pause and resume
        gate_i = 1'b1;
        fire_start(1, "R8");
        repeat (30) step("R8");
        fire_stop(0, "R8");
        chk(done_o == 1'b0, "R8", done_o, 0);
        for (int i = 0; i < 5; i++) begin
            step("R8");
            chk(wr_addr_o == 17'(wr_cnt), "R8", wr_addr_o, wr_cnt);
            chk(done_o == 1'b0 && samp_en_o == 1'b0, "R8", {done_o, samp_en_o}, 0);
        end
        fire_start(2, "R8");
        run_out("R8");
        chk(wr_cnt == 128, "R8", wr_cnt, 128);
        expect_done("R8");
        gate_i = 1'b0;

        // R9: disarmed until rearm
        start_dly_i = 8'd0;
        start_i = 1'b1; step("R9"); start_i = 1'b0;
        for (int i = 0; i < 10; i++) begin
            step("R9");
            chk(samp_en_o == 1'b0, "R9", samp_en_o, 0);
        end
        chk(wr_addr_o == 17'd127, "R9", wr_addr_o, 127);
        do_rearm("R9");
        fire_start(0, "R9");
        run_out("R9");
        chk(wr_cnt == 128, "R9", wr_cnt, 128);
        expect_done("R9");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule